// File: doc/BRIEF.md
# Four-Pin Configurable Serial-Channel I/O Port

This block gives one serial channel four multipurpose pins. Software sets each pin through its own two-bit code. The code chooses whether the pin is an input or an output, and when it is an output, what drives it. An output can carry an inverted software data bit, the channel's request-to-send or end-of-transmission signal, or one of the channel's 1x or 16x transmit or receive clocks. The clocks and modem signals come from the UART core and are only routed here.

Each pin also has a change-of-state detector with its own enable. Pin levels pass through a synchronizer. A detector sets a flag on either edge of its synchronized level. The input-port register returns these flags next to the live levels, and reading that register clears them. The interrupt request is the OR of the flags that are reported.

Top module: `chanIoPort`

## Requirements
- R1: After reset, the configuration register and the output/enable register are zero, every pin's output enable is 0, and the interrupt request is 0.
- R2: When pin k's code is 01 (config bits [2k+1:2k]) and no modem mode claims the pin, the pin is driven with the inverse of output-data bit k (output/enable register bit k).
- R3: Transmit clocks: pin 3 drives the 16x transmit clock with code 10 and the 1x transmit clock with code 11. Pin 0 drives the 1x transmit clock with code 10 and the 16x transmit clock with code 11.
- R4: Receive clocks: pin 2 drives the 1x receive clock with code 10 and the 16x receive clock with code 11. Pin 1 drives the 1x receive clock with code 11.
- R5: Pin 1 code 10 is reserved. The pin stays undriven, and its change detector works as it does for an input.
- R6: With pin 2 at code 01, pin 2 follows the request-to-send signal when the RTS mode input is 1. Otherwise it follows the end-of-transmission signal when the EOT mode input is 1. Otherwise it follows the inverted data bit 2.
- R7: With RTS mode set, pin 1 at code 01 and pin 2 at any code other than 01, pin 1 follows the request-to-send signal.
- R8: Reading address 2 returns the pin levels in bits [3:0] (1 = high), taken after a two-flop synchronizer, and the change flags in bits [7:4] (bit 4+k for pin k). Address 0 reads back the configuration register and address 1 reads back the output/enable register.
- R9: A change flag is set by any edge of its synchronized pin level. It reads 0 while its enable (output/enable register bit 4+k) is 0 or while its pin is an output.
- R10: Reading address 2 clears the change flags. An edge detected in the same cycle as the read still sets its flag.
- R11: The interrupt request equals the OR of the change flags as reported in the input-port register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 config, 1 output/enable, 2 input port |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid while regRd is high, otherwise 0 |
| txClk1x | input | 1 | 1x transmit clock |
| txClk16x | input | 1 | 16x transmit clock |
| rxClk1x | input | 1 | 1x receive clock |
| rxClk16x | input | 1 | 16x receive clock |
| rtsN | input | 1 | Request-to-send from the UART core |
| eotFlag | input | 1 | End-of-transmission signal from the UART core |
| rtsMode | input | 1 | RTS mode control bit |
| eotMode | input | 1 | End-of-transmission mode control bit |
| pinIn | input | 4 | Pad input levels |
| pinOut | output | 4 | Pad drive values |
| pinOe | output | 4 | Pad output enables |
| irq | output | 1 | Change-of-state interrupt request |

## Verification
The assertions check four things on every cycle: pins are released during reset, a code-01 pin 3 drives its inverted data bit, the reserved pin 1 code never drives, and the interrupt request and the reported flags only involve pins that are enabled inputs. Only the bench scenarios can show the rest. These cover the synchronizer latency, flags set by rising and by falling edges, clear-on-read, and the race between an edge and a read in the same cycle. They also cover the RTS, EOT and inverted-data priority on pin 2 and the RTS fallback to pin 1. The bench's reference model checks these against the pins and the read data on every clock.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int PIN_COUNT = 4;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 2 * PIN_COUNT;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ODR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IPR = 2'd2;

  localparam logic [1:0] CODE_IN  = 2'b00;
  localparam logic [1:0] CODE_DAT = 2'b01;
  localparam logic [1:0] CODE_A   = 2'b10;
  localparam logic [1:0] CODE_B   = 2'b11;

  typedef struct packed {
    logic              wrCfg;
    logic              wrOdr;
    logic              rdIpr;
    logic [DATA_W-1:0] data;
  } ioStrobe_t;
endpackage

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
  import ioport_pkg::*;
(
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] cfgReg,
  input  logic [DATA_W-1:0] odrReg,
  input  logic [DATA_W-1:0] iprVal,
  output ioStrobe_t         stb,
  output logic [DATA_W-1:0] regRdata
);
  always_comb begin
    stb.wrCfg = regWr && (regAddr == ADDR_CFG);
    stb.wrOdr = regWr && (regAddr == ADDR_ODR);
    stb.rdIpr = regRd && (regAddr == ADDR_IPR);
    stb.data  = regWdata;
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      case (regAddr)
        ADDR_CFG: regRdata = cfgReg;
        ADDR_ODR: regRdata = odrReg;
        ADDR_IPR: regRdata = iprVal;
        default:  regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ioport_dp.sv
module ioport_dp
  import ioport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ioStrobe_t            stb,
  input  logic                 txClk1x,
  input  logic                 txClk16x,
  input  logic                 rxClk1x,
  input  logic                 rxClk16x,
  input  logic                 rtsN,
  input  logic                 eotFlag,
  input  logic                 rtsMode,
  input  logic                 eotMode,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irq,
  output logic [DATA_W-1:0]    cfgReg,
  output logic [DATA_W-1:0]    odrReg,
  output logic [DATA_W-1:0]    iprVal
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] prevQ, flagQ, level, edgeHit, eligible, flagsOut, isIn;
  logic [1:0] code [PIN_COUNT];
  logic rtsOnPin1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      odrReg <= '0;
    end else begin
      if (stb.wrCfg) cfgReg <= stb.data;
      if (stb.wrOdr) odrReg <= stb.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  genvar g;
  generate
    for (g = 0; g < PIN_COUNT; g++) begin : gCode
      assign code[g] = cfgReg[2*g+1:2*g];
    end
  endgenerate

  assign rtsOnPin1 = rtsMode && (code[2] != CODE_DAT);

  always_comb begin
    pinOut = '0;
    pinOe  = '0;
    case (code[0])
      CODE_DAT: begin pinOe[0] = 1'b1; pinOut[0] = ~odrReg[0]; end
      CODE_A:   begin pinOe[0] = 1'b1; pinOut[0] = txClk1x;    end
      CODE_B:   begin pinOe[0] = 1'b1; pinOut[0] = txClk16x;   end
      default: ;
    endcase
    case (code[1])
      CODE_DAT: begin pinOe[1] = 1'b1; pinOut[1] = rtsOnPin1 ? rtsN : ~odrReg[1]; end
      CODE_B:   begin pinOe[1] = 1'b1; pinOut[1] = rxClk1x; end
      default: ;
    endcase
    case (code[2])
      CODE_DAT: begin
        pinOe[2]  = 1'b1;
        pinOut[2] = rtsMode ? rtsN : (eotMode ? eotFlag : ~odrReg[2]);
      end
      CODE_A:   begin pinOe[2] = 1'b1; pinOut[2] = rxClk1x;  end
      CODE_B:   begin pinOe[2] = 1'b1; pinOut[2] = rxClk16x; end
      default: ;
    endcase
    case (code[3])
      CODE_DAT: begin pinOe[3] = 1'b1; pinOut[3] = ~odrReg[3]; end
      CODE_A:   begin pinOe[3] = 1'b1; pinOut[3] = txClk16x;   end
      CODE_B:   begin pinOe[3] = 1'b1; pinOut[3] = txClk1x;    end
      default: ;
    endcase
  end

  assign isIn     = ~pinOe;
  assign level    = syncQ[LAST];
  assign edgeHit  = level ^ prevQ;
  assign eligible = odrReg[DATA_W-1:PIN_COUNT] & isIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flagQ <= '0;
    else if (stb.rdIpr) flagQ <= edgeHit & eligible;
    else                flagQ <= (flagQ | edgeHit) & eligible;
  end

  assign flagsOut = flagQ & eligible;
  assign irq      = |flagsOut;
  assign iprVal   = {flagsOut, level};
endmodule

// File: rtl/chanIoPort.sv
module chanIoPort
  import ioport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        txClk1x,
  input  logic        txClk16x,
  input  logic        rxClk1x,
  input  logic        rxClk16x,
  input  logic        rtsN,
  input  logic        eotFlag,
  input  logic        rtsMode,
  input  logic        eotMode,
  input  logic [3:0]  pinIn,
  output logic [3:0]  pinOut,
  output logic [3:0]  pinOe,
  output logic        irq
);
  ioStrobe_t         stb;
  logic [DATA_W-1:0] cfgReg, odrReg, iprVal;

  ioport_ctrl uCtrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .cfgReg(cfgReg), .odrReg(odrReg), .iprVal(iprVal),
    .stb(stb), .regRdata(regRdata)
  );

  ioport_dp #(.SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txClk1x(txClk1x), .txClk16x(txClk16x), .rxClk1x(rxClk1x), .rxClk16x(rxClk16x),
    .rtsN(rtsN), .eotFlag(eotFlag), .rtsMode(rtsMode), .eotMode(eotMode),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq),
    .cfgReg(cfgReg), .odrReg(odrReg), .iprVal(iprVal)
  );
endmodule

// File: rtl/ioport_checker.sv
module ioport_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regRd,
  input logic [1:0] regAddr,
  input logic [7:0] regRdata,
  input logic [3:0] pinOe,
  input logic [3:0] pinOut,
  input logic       irq,
  input logic [7:0] cfgReg,
  input logic [7:0] odrReg
);
  // R1: pins released and interrupt low while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_released: assert (pinOe == 4'b0000 && irq == 1'b0);
  end

  a_r2_pin3_inverse: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg[7:6] == 2'b01 |-> (pinOe[3] && pinOut[3] == !odrReg[3]));

  a_r5_reserved_undriven: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg[3:2] == 2'b10 |-> !pinOe[1]);

  a_r11_irq_needs_enabled_input: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((odrReg[7:4] & ~pinOe) != 4'b0000));

  a_r9_flags_masked: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 2'd2) |-> ((regRdata[7:4] & ~(odrReg[7:4] & ~pinOe)) == 4'b0000));
endmodule

bind chanIoPort ioport_checker uChk (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regAddr(regAddr), .regRdata(regRdata),
  .pinOe(pinOe), .pinOut(pinOut), .irq(irq), .cfgReg(cfgReg), .odrReg(odrReg)
);

// File: tb/tb_chanIoPort.sv
`timescale 1ns/1ps
module tb_chanIoPort;
  logic clk = 0, rstN = 0;
  logic regWr = 0, regRd = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic txClk1x = 0, txClk16x = 0, rxClk1x = 0, rxClk16x = 0;
  logic rtsN = 1, eotFlag = 0, rtsMode = 0, eotMode = 0;
  logic [3:0] pinIn = 0, pinOut, pinOe;
  logic irq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chanIoPort dut (.*);

  // Reference model state
  logic [7:0] mCfg = 0, mOdr = 0;
  logic [3:0] mS1 = 0, mS2 = 0, mPrev = 0, mFlags = 0;

  function automatic logic [3:0] inMask(logic [7:0] c);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) begin
      int code = c[2*k +: 2];
      m[k] = (code == 0) || (k == 1 && code == 2);
    end
    return m;
  endfunction

  task automatic expPins(output logic [3:0] o, output logic [3:0] e);
    o = 0; e = ~inMask(mCfg);
    for (int k = 0; k < 4; k++) begin
      int code = mCfg[2*k +: 2];
      if (code == 1) begin
        o[k] = !mOdr[k];
        if (k == 2 && rtsMode) o[k] = rtsN;
        else if (k == 2 && eotMode) o[k] = eotFlag;
        if (k == 1 && rtsMode && mCfg[5:4] != 2'b01) o[k] = rtsN;
      end else if (code == 2) begin
        if (k == 3) o[k] = txClk16x;
        if (k == 2) o[k] = rxClk1x;
        if (k == 0) o[k] = txClk1x;
      end else if (code == 3) begin
        if (k == 3) o[k] = txClk1x;
        if (k == 2) o[k] = rxClk16x;
        if (k == 1) o[k] = rxClk1x;
        if (k == 0) o[k] = txClk16x;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    logic [3:0] elig, edg;
    cyc++;
    if (!rstN) begin
      mCfg = 0; mOdr = 0; mS1 = 0; mS2 = 0; mPrev = 0; mFlags = 0;
    end else begin
      elig = mOdr[7:4] & inMask(mCfg);
      edg  = mS2 ^ mPrev;
      if (regRd && regAddr == 2) mFlags = edg & elig;
      else mFlags = (mFlags | edg) & elig;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
      if (regWr && regAddr == 0) mCfg = regWdata;
      if (regWr && regAddr == 1) mOdr = regWdata;
    end
  end

  // per-cycle comparison after inputs settle
  always @(negedge clk) begin
    logic [3:0] eo, ee, rep;
    logic [7:0] er;
    #1;
    if (rstN && !done) begin
      expPins(eo, ee);
      chk(pinOe == ee, "R2/R3/R4/R5 oe", pinOe, ee);
      chk((pinOut & ee) == (eo & ee), "R2/R3/R4/R6/R7 out", pinOut & ee, eo & ee);
      rep = mFlags & mOdr[7:4] & inMask(mCfg);
      chk(irq == |rep, "R11 irq", irq, |rep);
      if (regRd) begin
        er = (regAddr == 0) ? mCfg : (regAddr == 1) ? mOdr :
             (regAddr == 2) ? {rep, mS2} : 8'h00;
        chk(regRdata == er, "R8/R9/R10 read", regRdata, er);
      end
    end
  end

  // free-running clocks from the core
  int div = 0;
  always @(negedge clk) begin
    div++;
    txClk16x = ~txClk16x;
    rxClk16x = div[1];
    if (div % 8 == 0) txClk1x = ~txClk1x;
    if (div % 6 == 0) rxClk1x = ~rxClk1x;
  end

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWr = 0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regRd = 1; regAddr = a;
    #2 v = regRdata;
    @(posedge clk); #1 regRd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk(pinOe == 0 && irq == 0, "R1 reset outputs", {pinOe, 3'b0, irq}, 0);
    rstN = 1;
    rdReg(0, v); chk(v == 8'h00, "R1 cfg reset", v, 0);
    rdReg(1, v); chk(v == 8'h00, "R1 odr reset", v, 0);

    // R8: levels after the synchronizer, detectors off
    @(negedge clk) pinIn = 4'b1010;
    idle(4);
    rdReg(2, v); chk(v == 8'h0A, "R8 levels", v, 8'h0A);

    // R9: enabled detector, rising edge on pin 0
    wrReg(1, 8'hF0);
    @(negedge clk) pinIn = 4'b1011;
    idle(4);
    #1 chk(irq == 1, "R11 irq raised", irq, 1);
    rdReg(2, v); chk(v == 8'h1B, "R9 flag rise", v, 8'h1B);
    rdReg(2, v); chk(v == 8'h0B, "R10 cleared", v, 8'h0B);
    // falling edge on pin 3
    @(negedge clk) pinIn = 4'b0011;
    idle(4);
    rdReg(2, v); chk(v == 8'h83, "R9 flag fall", v, 8'h83);

    // R2: all pins code 01, outputs are inverted data
    wrReg(1, 8'hF5);
    wrReg(0, 8'h55);
    #1 chk(pinOe == 4'hF && pinOut == 4'b1010, "R2 inverse data", {pinOe, pinOut}, 8'hFA);
    @(negedge clk) pinIn = 4'b0000;
    idle(4);
    rdReg(2, v); chk(v[7:4] == 0, "R9 output pins no flag", v, 8'h00);

    // R6: pin 2 priority
    @(negedge clk) begin rtsMode = 1; rtsN = 0; end
    #1 chk(pinOut[2] == 0, "R6 rts low", pinOut[2], 0);
    @(negedge clk) rtsN = 1;
    #1 chk(pinOut[2] == 1, "R6 rts high", pinOut[2], 1);
    chk(pinOut[1] == 1, "R7 no fallback", pinOut[1], 1);
    @(negedge clk) begin rtsMode = 0; eotMode = 1; eotFlag = 1; end
    #1 chk(pinOut[2] == 1, "R6 eot", pinOut[2], 1);
    @(negedge clk) eotFlag = 0;
    #1 chk(pinOut[2] == 0, "R6 eot low", pinOut[2], 0);
    @(negedge clk) eotMode = 0;
    #1 chk(pinOut[2] == 0, "R6 data bit", pinOut[2], 0);

    // R7: fallback to pin 1
    wrReg(0, 8'h45);
    @(negedge clk) begin rtsMode = 1; rtsN = 0; end
    #1 chk(pinOut[1] == 0 && pinOe[2] == 0, "R7 fallback", {pinOut[1], pinOe[2]}, 0);
    @(negedge clk) begin rtsN = 1; rtsMode = 0; end

    // R3/R4/R5: clock codes and reserved code
    wrReg(0, 8'hAA);
    idle(10);
    #1 chk(pinOe == 4'b1101, "R5 reserved undriven", pinOe, 4'b1101);
    @(negedge clk) pinIn = 4'b0010;
    idle(4);
    rdReg(2, v); chk(v == 8'h22, "R5 reserved detects", v, 8'h22);
    wrReg(0, 8'hFF);
    idle(12);
    #1 chk(pinOe == 4'hF, "R4 clock codes oe", pinOe, 4'hF);

    // R10: edge in the same cycle as the read
    wrReg(0, 8'h00);
    rdReg(2, v);
    @(negedge clk) pinIn = 4'b0000;
    @(negedge clk);
    rdReg(2, v); chk(v == 8'h00, "R10 pending edge", v, 8'h00);
    rdReg(2, v); chk(v == 8'h20, "R10 edge survives read", v, 8'h20);
    rdReg(2, v); chk(v == 8'h00, "R10 cleared again", v, 8'h00);

    idle(5);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #160000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule